// File: doc/BRIEF.md
# Dual Programmable PWM Clock-Enable Generator

This block derives two independent clock-enable pulse trains, A and B, from the master clock. It does not make derived clocks. Each train is a one-cycle-wide enable pulse that the PWM channel counters use to advance. A single 32-bit mode register holds both configurations. The lower 16-bit half sets up generator A and the upper half sets up generator B.

Inside each half, an 8-bit linear divisor and a 4-bit power-of-two exponent set the pulse period. That period is the divisor multiplied by two to the power of the exponent, counted in master clock cycles. A half that is all zeros turns its generator off. A half with an out-of-range exponent or a zero divisor also turns its generator off.

Software writes the register through a single-cycle write strobe and reads it back on a plain data output. When a write changes a half, that generator restarts from the beginning of a period. When a write leaves a half unchanged, that generator keeps its phase.

Top module: `pwm_clkgen_dual`

## Requirements
- R1: While synchronous active-low reset is asserted, and after it is released, the mode register reads 0 and neither enable output pulses.
- R2: In the cycle after a write strobe, the readback output equals the written word.
- R3: Generator A takes its setup from mode bits [15:0] and drives `gen_tick[0]`. Generator B takes its setup from bits [31:16] and drives `gen_tick[1]`. Within a half, bits [7:0] hold the divisor d and bits [11:8] hold the exponent e. Bits [15:12] are stored but not used.
- R4: For e in 0..10 and d in 1..255, the enable output is high for one cycle in every 2^e*d cycles.
- R5: When e=0 and d=1, the period is one cycle, so the enable output is high in every cycle.
- R6: A half of all zeros produces no enable pulses.
- R7: An exponent above 10, or a zero divisor, produces no enable pulses.
- R8: A write that changes a half makes that output low in the cycle after the write edge. The output then first pulses exactly one period after that edge, and after that once per period.
- R9: A write that leaves a half unchanged does not disturb the phase of that generator.
- R10: The two generators are independent. A write that changes only one half does not disturb the phase of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Mode register write strobe, one cycle |
| cfg_wdata | input | 32 | Mode register write data |
| cfg_rdata | output | 32 | Mode register readback |
| gen_tick | output | 2 | Enable pulses: bit 0 from generator A, bit 1 from generator B |

## Verification
Two kinds of event can land in the same cycle. The first is a pulse from A coinciding with a pulse from B. The second is a configuration write arriving while a generator is mid-period or on a pulse edge.

Directed writes cover these overlaps. They give A and B periods with common multiples, both set to a period of one, and rewrite identical values at arbitrary phases. Seeded random configurations are written back to back, without waiting for period boundaries.

Each sampled cycle is judged per generator against a bench model. The model counts cycles from the last edge at which that half actually changed. It expects a pulse exactly when that count is a positive multiple of the period.

// File: rtl/pwmclk_pkg.sv
// Package: shared constants and field layout for the dual PWM clock generator.
// Assumes one configuration field per generator, laid out divisor-low, exponent-above.
package pwmclk_pkg;
    localparam int FIELD_W = 16;   // bits per generator field
    localparam int DIV_W   = 8;    // linear divisor width
    localparam int EXP_W   = 4;    // prescale exponent selector width
    localparam int EXP_MAX = 10;   // largest legal exponent
    localparam int NUM_GEN = 2;    // generators sharing the mode register

    typedef struct packed {
        logic [FIELD_W-DIV_W-EXP_W-1:0] spare;
        logic [EXP_W-1:0]               expo;
        logic [DIV_W-1:0]               divisor;
    } clk_field_t;
endpackage

// File: rtl/pwmclk_prescaler.sv
// Module: power-of-two prescale stage.
// Counts master cycles and emits pre_tick once every 2^expo cycles.
// Assumes expo <= EXP_MAX whenever active is high; restart or !active zeroes the count.
module pwmclk_prescaler #(
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 10,
    localparam int PRE_W  = (EXP_MAX > 0) ? EXP_MAX : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic [EXP_W-1:0] expo,
    output logic             pre_tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_mask;

    // Terminal count for the selected exponent.
    always_comb begin
        pre_mask = active ? PRE_W'((64'd1 << expo) - 64'd1) : '0;
        pre_tick = active && (pre_cnt == pre_mask);
    end

    // Free-running prescale counter, cleared on restart or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active)
            pre_cnt <= '0;
        else if (pre_tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // R4: the prescale count never passes its terminal value.
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pre_cnt <= pre_mask));
endmodule

// File: rtl/pwmclk_divider.sv
// Module: linear divisor stage.
// Counts prescale ticks and registers one enable pulse every `divisor` of them.
// Assumes divisor != 0 whenever active is high.
module pwmclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic [DIV_W-1:0] divisor,
    input  logic             pre_tick,
    output logic             tick_q
);
    logic [DIV_W-1:0] div_cnt;
    logic             div_last;

    // Last prescale tick of the current output period.
    always_comb div_last = (div_cnt == (divisor - DIV_W'(1)));

    // Divisor counter, advanced on prescale ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active)
            div_cnt <= '0;
        else if (pre_tick)
            div_cnt <= div_last ? '0 : div_cnt + DIV_W'(1);
    end

    // Registered one-cycle enable output.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active)
            tick_q <= 1'b0;
        else
            tick_q <= pre_tick && div_last;
    end

    // R4: the divisor count stays below the programmed divisor.
    a_r4_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (div_cnt < divisor));
endmodule

// File: rtl/pwmclk_gen.sv
// Module: one complete clock-enable generator (prescale stage then divisor stage).
// Decides from its field whether it is active; an illegal or zero field keeps it silent.
module pwmclk_gen #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);
    logic active;
    logic pre_tick;

    // Generator runs only with a legal exponent and a nonzero divisor.
    always_comb active = (divisor != '0) && (expo <= EXP_W'(EXP_MAX));

    pwmclk_prescaler #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .active   (active),
        .expo     (expo),
        .pre_tick (pre_tick)
    );

    pwmclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .active   (active),
        .divisor  (divisor),
        .pre_tick (pre_tick),
        .tick_q   (tick)
    );

    // R6/R7: an inactive generator never pulses.
    a_r7_inactive_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !tick);
    // R8: a restart leaves the output low in the following cycle.
    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    // R4: with period above one, a pulse is never followed by another.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && !(expo == '0 && divisor == DIV_W'(1))) |=> !tick);
endmodule

// File: rtl/pwm_clkgen_dual.sv
// Module: top of the dual PWM clock-enable generator.
// Holds the shared mode register and restarts a generator only when its field changes.
// Assumes cfg_wr is a single-cycle strobe synchronous to clk.
module pwm_clkgen_dual
    import pwmclk_pkg::*;
#(
    parameter int N_GEN   = NUM_GEN,
    parameter int FLD_W   = FIELD_W,
    parameter int DV_W    = DIV_W,
    parameter int EX_W    = EXP_W,
    parameter int EX_MAX  = EXP_MAX,
    localparam int REG_W  = N_GEN * FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [N_GEN-1:0] gen_tick
);
    logic [REG_W-1:0] mode_q;
    logic [N_GEN-1:0] field_chg;

    // Mode register, written by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (cfg_wr)
            mode_q <= cfg_wdata;
    end

    // Readback of the whole register.
    always_comb cfg_rdata = mode_q;

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        // A write restarts this generator only when its own field differs.
        always_comb field_chg[g] = cfg_wr &&
            (cfg_wdata[g*FLD_W +: FLD_W] != mode_q[g*FLD_W +: FLD_W]);

        pwmclk_gen #(.DIV_W(DV_W), .EXP_W(EX_W), .EXP_MAX(EX_MAX)) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (field_chg[g]),
            .divisor (mode_q[g*FLD_W +: DV_W]),
            .expo    (mode_q[g*FLD_W + DV_W +: EX_W]),
            .tick    (gen_tick[g])
        );
    end

    // R2: readback shows the written word after a write.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/pwm_clkgen_dual_tb.sv
`timescale 1ns/1ps
module pwm_clkgen_dual_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  gen_tick;

    int          cyc = 0;
    int          errs = 0;
    int          checks = 0;
    int          org [2] = '{0, 0};
    logic [31:0] shadow = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_clkgen_dual u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .gen_tick  (gen_tick)
    );

    // Period in cycles of a field, 0 when the field is off.
    function automatic int period_of(logic [15:0] f);
        int d = int'(f[7:0]);
        int e = int'(f[11:8]);
        if (d == 0 || e > 10) return 0;
        return (1 << e) * d;
    endfunction

    function automatic logic exp_tick(int g);
        int p = period_of(shadow[g*16 +: 16]);
        int k = cyc - org[g];
        return (p != 0) && (k > 0) && ((k % p) == 0);
    endfunction

    task automatic check_val(string req, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, expv, cyc);
        end
    endtask

    task automatic compare_ticks(string req);
        for (int g = 0; g < 2; g++)
            check_val(req, (g == 0) ? "tick A" : "tick B", longint'(gen_tick[g]), longint'(exp_tick(g)));
    endtask

    task automatic observe(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_ticks(req);
        end
    endtask

    task automatic write_cfg(logic [31:0] v, string req);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        for (int g = 0; g < 2; g++)
            if (shadow[g*16 +: 16] != v[g*16 +: 16]) org[g] = cyc;
        shadow = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        check_val("R2", "readback", longint'(cfg_rdata), longint'(v));
        compare_ticks(req);   // R8: changed field is quiet right after the edge
    endtask

    function automatic logic [15:0] rand_field();
        int r = int'($urandom % 16);
        if (r == 0) return 16'h0000;
        if (r == 1) return {4'h0, 4'(11 + $urandom % 5), 8'(1 + $urandom % 200)};
        return {4'($urandom % 16), 4'($urandom % 7), 8'(1 + $urandom % 24)};
    endfunction

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1", "readback in reset", longint'(cfg_rdata), 0);
        check_val("R1", "ticks in reset", longint'(gen_tick), 0);
        rst_n = 1'b1;
        observe(20, "R1");
        // R5: period of one cycle on A
        write_cfg(32'h0000_0001, "R5");
        observe(10, "R5");
        // R3: A exp1 div2 (4 cycles), B exp3 div5 (40 cycles)
        write_cfg(32'h0305_0102, "R3");
        observe(97, "R3");
        // R9: rewrite identical value mid-phase
        write_cfg(32'h0305_0102, "R9");
        observe(90, "R9");
        // R10: change A only, B keeps phase
        write_cfg(32'h0305_0007, "R10");
        observe(123, "R10");
        // R7: exponent above 10 on A, R6: zero field on B
        write_cfg(32'h0000_0B05, "R7");
        observe(200, "R6");
        // R7: zero divisor with nonzero exponent on B, A off
        write_cfg(32'h0300_0000, "R7");
        observe(100, "R7");
        // R4: longest exponent and largest divisor
        write_cfg(32'h00FF_0A01, "R4");
        observe(2100, "R4");
        // R5/R8: both at one-cycle period, then restart both
        write_cfg(32'h0001_0001, "R5");
        observe(8, "R5");
        write_cfg(32'h0102_0102, "R8");
        observe(20, "R8");
        // R4/R8/R9/R10: seeded random configurations written at arbitrary phase
        for (int it = 0; it < 20; it++) begin
            logic [31:0] v;
            int pa;
            int pb;
            int n;
            v = (it % 5 == 4) ? {shadow[31:16], rand_field()} : {rand_field(), rand_field()};
            write_cfg(v, "R8");
            pa = period_of(v[15:0]);
            pb = period_of(v[31:16]);
            n = 2 * ((pa > pb) ? pa : pb) + 4 + int'($urandom % 13);
            if (n > 3000) n = 3000;
            observe(n, "R4");
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule